// File: doc/BRIEF.md
# Ferroelectric Crosspoint Line-Drive Sequencer

This block sequences row accesses to a small ferroelectric crosspoint memory. Each accepted command names a row. The block first runs a destructive read of that whole row. During the read the selected word line carries full write voltage and every cell on the row is sensed in parallel by one charge integrator per bit line. The read also leaves every cell on the row holding 1. The block then merges the sensed data with the command's masked write data. If any column must hold 0, it runs a single write-0 phase for those columns. The bias levels in that phase keep every other cell at no more than one third of the write voltage.

Every word line and bit line gets a 2-bit drive code for the analog drivers outside the block. A sample strobe tells the integrators when to latch, and their comparator outputs come back as one bit per column. Commands arrive on a valid/ready handshake. A one-cycle done pulse comes with the row data as it was before the access. A command with an all-zero mask is therefore a plain read that restores the row.

Top module: `fe_xpoint_seq`

## Requirements
- R1: The 3-bit row field selects exactly one word line (one-hot, row n drives word line n); no other row is ever driven as selected.
- R2: Drive codes are 00 ground, 01 one third, 10 two thirds, 11 full. The read phase lasts cfgReadCycles cycles, with 0 treated as 1. In it the selected word line is 11, every other word line is 00 and every bit line is 00.
- R3: sampleStrobe is high for exactly one cycle per command, in the last read-phase cycle. senseBits is captured at the end of that cycle, with bit c = 1 meaning column c held 1. The captured word is returned on rdData.
- R4: The stored row becomes (cmdWrMask & cmdWrData) | (~cmdWrMask & read data). The columns that get a 0 are the zero bits of that word. A zero mask restores the row unchanged.
- R5: The write-0 phase lasts cfgWriteCycles cycles, with 0 treated as 1. In it the selected word line is 00, all other word lines are 10, bit lines of columns getting a 0 are 11 and all other bit lines are 01.
- R6: When the merged word is all ones, the write-0 phase is skipped entirely.
- R7: Each phase is followed by one cycle in which every line is 00. No line ever changes directly from one nonzero code to a different nonzero code.
- R8: In every cycle, only cells on the addressed row may see a code difference between word line and bit line greater than one step.
- R9: cmdReady is high only while idle, and a command is taken only when cmdValid and cmdReady are both high. Command inputs presented while busy have no effect.
- R10: done is a one-cycle pulse in the final all-ground cycle. Counting the cycle after acceptance as cycle 1, it falls in cycle R+1 when the write is skipped and in cycle R+W+2 otherwise, where R and W are the effective phase lengths. cmdReady is high again in the next cycle.
- R11: During and after reset the block is idle: cmdReady high, every drive code 00, sampleStrobe and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command valid |
| cmdReady | output | 1 | Sequencer idle, command can be taken |
| cmdRow | input | ROW_AW | Row address |
| cmdWrData | input | COLS | Write data for masked columns |
| cmdWrMask | input | COLS | 1 = column takes cmdWrData, 0 = column keeps read value |
| cfgReadCycles | input | CNT_W | Read phase length in cycles (0 acts as 1) |
| cfgWriteCycles | input | CNT_W | Write-0 phase length in cycles (0 acts as 1) |
| wlDrive | output | 2*2^ROW_AW | Drive code per word line, row r at bits [2r+1:2r] |
| blDrive | output | 2*COLS | Drive code per bit line, column c at bits [2c+1:2c] |
| sampleStrobe | output | 1 | Integrator sample strobe |
| senseBits | input | COLS | Comparator results, 1 = cell held 1 |
| done | output | 1 | Sequence complete pulse |
| rdData | output | COLS | Row data sensed by the read phase |

## Verification
The bench keeps a model of the cell array that reacts only to full-bias drive codes. A wrong merge or a wrong target column therefore appears as bad data on a later read of the same row, and a wrong row decode leaves the read-phase counter for the addressed line at zero. It counts read and write cycles against the configured lengths, including zero lengths, so an off-by-one phase counter or a strobe one cycle early shows up as a mismatched count or a wrong strobe cycle. A design that skipped the ground cycle between phases would show a line stepping between two nonzero codes. A design that ran the write phase when every column stays 1 would report a late done. A command presented while busy that was taken anyway would corrupt the neighbouring row, and a later read of that row exposes it.

// File: rtl/fe_xpt_pkg.sv
`timescale 1ns/1ps
package fe_xpt_pkg;

  // Line drive levels in thirds of the write voltage.
  typedef enum logic [1:0] {
    LVL_GND       = 2'b00,
    LVL_THIRD     = 2'b01,
    LVL_TWO_THIRD = 2'b10,
    LVL_FULL      = 2'b11
  } lvl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_RGAP,
    ST_WRITE,
    ST_WGAP
  } seqState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic accept;      // command taken this cycle
    logic capture;     // last read cycle, latch sense results
    logic readPhase;   // drive read levels
    logic writePhase;  // drive write-0 levels
  } seqStrobe_t;

endpackage

// File: rtl/fe_xpt_row_dec.sv
`timescale 1ns/1ps
module fe_xpt_row_dec #(
  parameter int ROW_AW = 3,
  localparam int ROWS = 1 << ROW_AW
) (
  input  logic [ROW_AW-1:0] rowAddr,
  output logic [ROWS-1:0]   rowSel
);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign rowSel[i] = (rowAddr == ROW_AW'(i));
  end

endmodule

// File: rtl/fe_xpt_ctrl.sv
`timescale 1ns/1ps
module fe_xpt_ctrl
  import fe_xpt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [CNT_W-1:0] cfgReadCycles,
  input  logic [CNT_W-1:0] cfgWriteCycles,
  input  logic             needWrite,
  output seqStrobe_t       strobes,
  output logic             sampleStrobe,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seqState_e        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] rdLenQ;
  logic [CNT_W-1:0] wrLenQ;
  logic             accept;
  logic             rdLast;
  logic             wrLast;

  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  assign rdLast   = (state == ST_READ)  && (phaseCnt == rdLenQ - ONE);
  assign wrLast   = (state == ST_WRITE) && (phaseCnt == wrLenQ - ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      rdLenQ   <= ONE;
      wrLenQ   <= ONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            rdLenQ   <= (cfgReadCycles  == '0) ? ONE : cfgReadCycles;
            wrLenQ   <= (cfgWriteCycles == '0) ? ONE : cfgWriteCycles;
            phaseCnt <= '0;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (rdLast) begin
            phaseCnt <= '0;
            state    <= ST_RGAP;
          end else begin
            phaseCnt <= phaseCnt + ONE;
          end
        end
        ST_RGAP: begin
          state <= needWrite ? ST_WRITE : ST_IDLE;
        end
        ST_WRITE: begin
          if (wrLast) begin
            phaseCnt <= '0;
            state    <= ST_WGAP;
          end else begin
            phaseCnt <= phaseCnt + ONE;
          end
        end
        ST_WGAP: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.accept     = accept;
    strobes.capture    = rdLast;
    strobes.readPhase  = (state == ST_READ);
    strobes.writePhase = (state == ST_WRITE);
  end

  assign sampleStrobe = rdLast;
  assign done = ((state == ST_RGAP) && !needWrite) || (state == ST_WGAP);

endmodule

// File: rtl/fe_xpt_datapath.sv
`timescale 1ns/1ps
module fe_xpt_datapath
  import fe_xpt_pkg::*;
#(
  parameter int ROW_AW = 3,
  parameter int COLS   = 4,
  localparam int ROWS  = 1 << ROW_AW
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobes,
  input  logic [ROW_AW-1:0]   cmdRow,
  input  logic [COLS-1:0]     cmdWrData,
  input  logic [COLS-1:0]     cmdWrMask,
  input  logic [COLS-1:0]     senseBits,
  input  logic [ROWS-1:0]     rowSel,
  output logic [ROW_AW-1:0]   rowQ,
  output logic                needWrite,
  output logic [COLS-1:0]     rdData,
  output logic [2*ROWS-1:0]   wlDrive,
  output logic [2*COLS-1:0]   blDrive
);

  logic [COLS-1:0] dataQ;
  logic [COLS-1:0] maskQ;
  logic [COLS-1:0] rdQ;
  logic [COLS-1:0] mergedWord;
  logic [COLS-1:0] zeroCols;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ  <= '0;
      dataQ <= '0;
      maskQ <= '0;
      rdQ   <= '0;
    end else begin
      if (strobes.accept) begin
        rowQ  <= cmdRow;
        dataQ <= cmdWrData;
        maskQ <= cmdWrMask;
      end
      if (strobes.capture) begin
        rdQ <= senseBits;
      end
    end
  end

  assign mergedWord = (maskQ & dataQ) | (~maskQ & rdQ);
  assign zeroCols   = ~mergedWord;
  assign needWrite  = |zeroCols;
  assign rdData     = rdQ;

  for (genvar r = 0; r < ROWS; r++) begin : g_wl
    lvl_e wlLvl;
    always_comb begin
      if (strobes.readPhase) begin
        wlLvl = rowSel[r] ? LVL_FULL : LVL_GND;
      end else if (strobes.writePhase) begin
        wlLvl = rowSel[r] ? LVL_GND : LVL_TWO_THIRD;
      end else begin
        wlLvl = LVL_GND;
      end
    end
    assign wlDrive[2*r +: 2] = wlLvl;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_bl
    lvl_e blLvl;
    always_comb begin
      if (strobes.writePhase) begin
        blLvl = zeroCols[c] ? LVL_FULL : LVL_THIRD;
      end else begin
        blLvl = LVL_GND;
      end
    end
    assign blDrive[2*c +: 2] = blLvl;
  end

endmodule

// File: rtl/fe_xpoint_seq.sv
`timescale 1ns/1ps
module fe_xpoint_seq
  import fe_xpt_pkg::*;
#(
  parameter int ROW_AW = 3,
  parameter int COLS   = 4,
  parameter int CNT_W  = 8,
  localparam int ROWS  = 1 << ROW_AW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [ROW_AW-1:0]   cmdRow,
  input  logic [COLS-1:0]     cmdWrData,
  input  logic [COLS-1:0]     cmdWrMask,
  input  logic [CNT_W-1:0]    cfgReadCycles,
  input  logic [CNT_W-1:0]    cfgWriteCycles,
  output logic [2*ROWS-1:0]   wlDrive,
  output logic [2*COLS-1:0]   blDrive,
  output logic                sampleStrobe,
  input  logic [COLS-1:0]     senseBits,
  output logic                done,
  output logic [COLS-1:0]     rdData
);

  seqStrobe_t        strobes;
  logic              needWrite;
  logic [ROW_AW-1:0] rowQ;
  logic [ROWS-1:0]   rowSel;

  fe_xpt_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .cmdValid      (cmdValid),
    .cmdReady      (cmdReady),
    .cfgReadCycles (cfgReadCycles),
    .cfgWriteCycles(cfgWriteCycles),
    .needWrite     (needWrite),
    .strobes       (strobes),
    .sampleStrobe  (sampleStrobe),
    .done          (done)
  );

  fe_xpt_row_dec #(.ROW_AW(ROW_AW)) dec_i (
    .rowAddr(rowQ),
    .rowSel (rowSel)
  );

  fe_xpt_datapath #(.ROW_AW(ROW_AW), .COLS(COLS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmdRow   (cmdRow),
    .cmdWrData(cmdWrData),
    .cmdWrMask(cmdWrMask),
    .senseBits(senseBits),
    .rowSel   (rowSel),
    .rowQ     (rowQ),
    .needWrite(needWrite),
    .rdData   (rdData),
    .wlDrive  (wlDrive),
    .blDrive  (blDrive)
  );

endmodule

// File: rtl/fe_xpoint_seq_chk.sv
`timescale 1ns/1ps
module fe_xpoint_seq_chk #(
  parameter int ROW_AW = 3,
  parameter int COLS   = 4,
  localparam int ROWS  = 1 << ROW_AW,
  localparam int NLINE = ROWS + COLS
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic [2*ROWS-1:0] wlDrive,
  input logic [2*COLS-1:0] blDrive,
  input logic              sampleStrobe,
  input logic              done
);

  logic [ROWS-1:0]    wlFull;
  logic [ROWS-1:0]    wlGnd;
  logic [ROWS-1:0]    rowOver;
  logic [COLS-1:0]    blFull;
  logic [2*NLINE-1:0] allLines;
  logic               allGround;

  assign allLines  = {wlDrive, blDrive};
  assign allGround = (allLines == '0);

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      blFull[c] = (blDrive[2*c +: 2] == 2'b11);
    end
    for (int r = 0; r < ROWS; r++) begin
      logic [1:0] w;
      w = wlDrive[2*r +: 2];
      wlFull[r]  = (w == 2'b11);
      wlGnd[r]   = (w == 2'b00);
      rowOver[r] = 1'b0;
      for (int c = 0; c < COLS; c++) begin
        logic [1:0] b;
        logic [1:0] d;
        b = blDrive[2*c +: 2];
        d = (w > b) ? (w - b) : (b - w);
        if (d > 2'd1) rowOver[r] = 1'b1;
      end
    end
  end

  AST_ONE_FULL_WL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wlFull)); // R1

  AST_READ_BL_GND: assert property (@(posedge clk) disable iff (!rstN)
    (|wlFull) |-> (blDrive == '0)); // R2

  AST_STROBE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> ($countones(wlFull) == 1)); // R3

  AST_STROBE_THEN_GAP: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> allGround); // R7

  AST_WRITE_ONE_GND_WL: assert property (@(posedge clk) disable iff (!rstN)
    (|blFull) |-> ($countones(wlGnd) == 1)); // R5

  AST_DISTURB_ONE_ROW: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rowOver)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> (allGround && !sampleStrobe)); // R9

  AST_DONE_GROUND: assert property (@(posedge clk) disable iff (!rstN)
    done |-> allGround); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && cmdReady)); // R10

  for (genvar k = 0; k < NLINE; k++) begin : g_step
    AST_NO_DIRECT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (($past(allLines[2*k +: 2]) != 2'b00) && (allLines[2*k +: 2] != 2'b00))
        |-> (allLines[2*k +: 2] == $past(allLines[2*k +: 2]))); // R7
  end

endmodule

bind fe_xpoint_seq fe_xpoint_seq_chk #(.ROW_AW(ROW_AW), .COLS(COLS)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .cmdReady    (cmdReady),
  .wlDrive     (wlDrive),
  .blDrive     (blDrive),
  .sampleStrobe(sampleStrobe),
  .done        (done)
);

// File: tb/fe_xpoint_seq_tb.sv
`timescale 1ns/1ps
module fe_xpoint_seq_tb_top;

  localparam int ROW_AW = 3;
  localparam int COLS   = 4;
  localparam int CNT_W  = 8;
  localparam int ROWS   = 1 << ROW_AW;

  typedef struct packed {
    logic [2:0] row;
    logic [3:0] data;
    logic [3:0] mask;
    logic [3:0] expRd;
    logic [7:0] rdLen;
    logic [7:0] wrLen;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{3'd2, 4'h0, 4'hF, 4'hF, 8'd3, 8'd2},
    '{3'd2, 4'h0, 4'h0, 4'h0, 8'd1, 8'd1},
    '{3'd2, 4'hA, 4'h3, 4'h0, 8'd2, 8'd3},
    '{3'd5, 4'h5, 4'hF, 4'hF, 8'd4, 8'd2},
    '{3'd2, 4'h0, 4'h0, 4'h2, 8'd3, 8'd1},
    '{3'd5, 4'hF, 4'hC, 4'h5, 8'd2, 8'd4},
    '{3'd5, 4'h0, 4'h0, 4'hD, 8'd1, 8'd2},
    '{3'd0, 4'hF, 4'hF, 4'hF, 8'd3, 8'd3},
    '{3'd7, 4'h8, 4'h8, 4'hF, 8'd2, 8'd2},
    '{3'd2, 4'h0, 4'h0, 4'h2, 8'd5, 8'd5}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [ROW_AW-1:0] cmdRow = '0;
  logic [COLS-1:0]   cmdWrData = '0;
  logic [COLS-1:0]   cmdWrMask = '0;
  logic [CNT_W-1:0]  cfgReadCycles = '0;
  logic [CNT_W-1:0]  cfgWriteCycles = '0;
  logic [2*ROWS-1:0] wlDrive;
  logic [2*COLS-1:0] blDrive;
  logic              sampleStrobe;
  logic [COLS-1:0]   senseBits = '0;
  logic              done;
  logic [COLS-1:0]   rdData;

  int nChk = 0;
  int nFail = 0;

  // Cell array model: only full-bias cells change state.
  logic [COLS-1:0] cellModel [ROWS];

  always #4 clk = ~clk;

  fe_xpoint_seq #(.ROW_AW(ROW_AW), .COLS(COLS), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdRow(cmdRow), .cmdWrData(cmdWrData), .cmdWrMask(cmdWrMask),
    .cfgReadCycles(cfgReadCycles), .cfgWriteCycles(cfgWriteCycles),
    .wlDrive(wlDrive), .blDrive(blDrive), .sampleStrobe(sampleStrobe),
    .senseBits(senseBits), .done(done), .rdData(rdData)
  );

  always @(posedge clk) begin
    if (rstN) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (wlDrive[2*r +: 2] == 2'b11 && blDrive[2*c +: 2] == 2'b00)
            cellModel[r][c] <= 1'b1;
          else if (wlDrive[2*r +: 2] == 2'b00 && blDrive[2*c +: 2] == 2'b11)
            cellModel[r][c] <= 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic runCmd(input logic [2:0] row, input logic [3:0] data,
                        input logic [3:0] mask, input logic [3:0] expRd,
                        input int rdLen, input int wrLen, input bit noise);
    int rlE = (rdLen == 0) ? 1 : rdLen;
    int wlE = (wrLen == 0) ? 1 : wrLen;
    logic [3:0] newWord = (mask & data) | (~mask & expRd);
    bit skip = (newWord == 4'hF);
    int expDone = skip ? rlE + 1 : rlE + wlE + 2;
    int cyc = 1;
    int rdCyc = 0;
    int wrCyc = 0;
    int strobeN = 0;
    int strobeAt = 0;
    bit badLvl = 0;
    bit badStep = 0;
    bit badReady = 0;
    bit badDisturb = 0;
    bit timedOut = 0;
    logic [2*ROWS+2*COLS-1:0] prevLines = '0;
    logic [2*ROWS+2*COLS-1:0] curLines;

    @(negedge clk);
    check(cmdReady == 1'b1, "R9", "ready while idle", cmdReady, 1);
    senseBits      = cellModel[row];
    cmdRow         = row;
    cmdWrData      = data;
    cmdWrMask      = mask;
    cfgReadCycles  = CNT_W'(rdLen);
    cfgWriteCycles = CNT_W'(wrLen);
    cmdValid       = 1'b1;
    @(negedge clk);
    if (noise) begin
      // Competing command while busy: would clear the neighbouring row.
      cmdRow    = row ^ 3'd1;
      cmdWrData = 4'h0;
      cmdWrMask = 4'hF;
    end else begin
      cmdValid = 1'b0;
    end
    forever begin
      curLines = {wlDrive, blDrive};
      if (wlDrive[2*row +: 2] == 2'b11) begin
        rdCyc++;
        for (int r = 0; r < ROWS; r++)
          if (r != row && wlDrive[2*r +: 2] != 2'b00) badLvl = 1;
        if (blDrive != '0) badLvl = 1;
      end
      if (blDrive != '0) begin
        wrCyc++;
        for (int r = 0; r < ROWS; r++)
          if (wlDrive[2*r +: 2] != ((r == row) ? 2'b00 : 2'b10)) badLvl = 1;
        for (int c = 0; c < COLS; c++)
          if (blDrive[2*c +: 2] != (newWord[c] ? 2'b01 : 2'b11)) badLvl = 1;
      end
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          int w = int'(wlDrive[2*r +: 2]);
          int b = int'(blDrive[2*c +: 2]);
          if (r != row && (w - b > 1 || b - w > 1)) badDisturb = 1;
        end
      end
      for (int k = 0; k < ROWS + COLS; k++) begin
        if (prevLines[2*k +: 2] != 2'b00 && curLines[2*k +: 2] != 2'b00 &&
            prevLines[2*k +: 2] != curLines[2*k +: 2]) badStep = 1;
      end
      prevLines = curLines;
      if (sampleStrobe) begin
        strobeN++;
        strobeAt = cyc;
      end
      if (cmdReady) badReady = 1;
      if (noise && cyc == 1) cmdValid = 1'b0;
      if (done) break;
      if (cyc > 600) begin
        timedOut = 1;
        break;
      end
      @(negedge clk);
      cyc++;
    end
    cmdValid = 1'b0;
    check(!timedOut, "R10", "done seen", timedOut, 0);
    check(rdData == expRd, "R3", "rdData", rdData, expRd);
    check(cyc == expDone, "R10", "done cycle", cyc, expDone);
    check(strobeN == 1 && strobeAt == rlE, "R3", "strobe cycle", strobeAt, rlE);
    check(rdCyc == rlE, "R1", "read cycles on addressed row", rdCyc, rlE);
    check(wrCyc == (skip ? 0 : wlE), "R6", "write-0 cycles", wrCyc, skip ? 0 : wlE);
    check(!badLvl, "R5", "phase drive levels", badLvl, 0);
    check(!badStep, "R7", "ground cycle between levels", badStep, 0);
    check(!badDisturb, "R8", "unaddressed cell bias", badDisturb, 0);
    check(!badReady, "R9", "ready low while busy", badReady, 0);
    @(negedge clk);
    check(cellModel[row] == newWord, "R4", "stored row", cellModel[row], newWord);
    check(cmdReady && !done, "R10", "idle after done", {cmdReady, done}, 2'b10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++) cellModel[r] = '1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(cmdReady == 1'b1, "R11", "ready in reset", cmdReady, 1);
    check(wlDrive == '0 && blDrive == '0, "R11", "drives in reset",
          int'({wlDrive, blDrive}), 0);
    check(!sampleStrobe && !done, "R11", "strobe/done in reset",
          {sampleStrobe, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady && wlDrive == '0 && blDrive == '0 && !done, "R11",
          "idle after reset", {cmdReady, done}, 2'b10);

    for (int i = 0; i < NVEC; i++) begin
      runCmd(VEC[i].row, VEC[i].data, VEC[i].mask, VEC[i].expRd,
             int'(VEC[i].rdLen), int'(VEC[i].wrLen), 1'b0);
    end

    // R2 R5: zero-length configuration acts as one cycle
    runCmd(3'd3, 4'h0, 4'hF, 4'hF, 0, 0, 1'b0);
    // R9: command held during busy on row 4 targets row 5, must be ignored
    runCmd(3'd4, 4'h0, 4'h0, 4'hF, 2, 2, 1'b1);
    runCmd(3'd5, 4'h0, 4'h0, 4'hD, 1, 1, 1'b0);
    // R4: row 3 holds zeros after the zero-length write
    runCmd(3'd3, 4'h0, 4'h0, 4'h0, 2, 3, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule